// File: doc/BRIEF.md
# Processor Status Register with Flag and Bus Write Arbitration

This block holds the 8-bit status word of a small 8-bit processor core. The word combines three kinds of bits. The first kind is the bank-select bits used by direct and indirect data-memory addressing. The second is two reset-cause bits, which only hardware events can change. The third is the zero, digit-carry and carry flags produced by the ALU. The core reaches the block through two paths. One is an ordinary register-file write aimed at this register. The other is a per-flag update from the ALU. The block decides, bit by bit, which source wins.

Flag results are written by the ALU whenever their update enable is high. If an instruction writes this register through the bus and also updates any flag, the bus data for all three flag bits is dropped. Enabled flags take the ALU result and the others keep their value. Bank bits always take the bus data. Bit-set, bit-clear, swap and move instructions raise no flag enable, so every writable bit takes the bus data.

The two reset-cause bits follow power-up, the watchdog-clear instruction, the sleep instruction and a watchdog expiry. They ignore bus data. All inputs are single-cycle control strobes with no handshake, so there is no back-pressure. A value presented before a rising clock edge is visible on the outputs after that edge.

Top module: `cpu_status_reg`

## Requirements
- R1: While the active-low reset is asserted, the word reads 0x18: the bank bits are 000, the time-out bit and the power-down bit are both 1, and this implementation also clears the three flags.
- R2: The word is laid out, from bit 7 down to bit 0, as: indirect bank bit, direct bank high, direct bank low, time-out, power-down, zero, digit-carry, carry. A bus write with no flag enable loads bits 7:5 and 2:0 from the bus data at the next edge.
- R3: A bus write together with any flag enable still loads bits 7:5 from the bus data. Bus data for bits 2:0 is discarded: each enabled flag takes its ALU value and each other flag holds.
- R4: With no bus write, each flag whose enable is high takes its ALU value and each flag whose enable is low holds.
- R5: Bus writes never change the time-out or power-down bits.
- R6: A watchdog-clear event sets both time-out and power-down.
- R7: A sleep event sets time-out and clears power-down.
- R8: A watchdog expiry clears time-out and leaves power-down unchanged.
- R9: When an expiry arrives together with a watchdog-clear or sleep event, time-out is cleared. Power-down still follows the other event (set by clear, cleared by sleep).
- R10: ind_bank always equals bit 7 of the word and dir_bank equals bits 6:5.
- R11: A clear instruction (bus write of 0x00 with only the zero enable, ALU zero=1) gives 000u_u1uu: bank bits 0, zero set, other bits unchanged.
- R12: When sleep and watchdog-clear arrive together, time-out is set and power-down is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| bus_wr_en | input | 1 | Register-file write aimed at this register |
| bus_wr_data | input | 8 | Bus write data |
| alu_z_we | input | 1 | Zero flag update enable |
| alu_dc_we | input | 1 | Digit-carry flag update enable |
| alu_c_we | input | 1 | Carry flag update enable |
| alu_z | input | 1 | ALU zero result |
| alu_dc | input | 1 | ALU digit-carry (active-low borrow on subtract) |
| alu_c | input | 1 | ALU carry (borrow on subtract, shifted-out bit on rotate) |
| wdt_clear_evt | input | 1 | Watchdog-clear instruction executed |
| sleep_evt | input | 1 | Sleep instruction executed |
| wdt_expire_evt | input | 1 | Watchdog timer expired |
| status_q | output | 8 | Status word |
| ind_bank | output | 1 | Bank bit for indirect addressing |
| dir_bank | output | 2 | Bank field for direct addressing |

## Verification
The hardest case to reach from the ports is a single cycle that carries a bus write and a partial set of flag enables at once. In that cycle some flags must hold while their bus data bits differ from the held value. The stimulus table first loads known flag values through plain ALU updates. It then issues a bus write whose data disagrees with every flag and enables only one of them, so the discarded data and the held flags can be seen. Simultaneous watchdog events are reached the same way, from a known time-out and power-down state.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned WORD_W  = 8;
  localparam int unsigned FLAG_N  = 3;
  localparam int unsigned BANK_N  = 3;
  localparam int unsigned IDX_C   = 0;
  localparam int unsigned IDX_DC  = 1;
  localparam int unsigned IDX_Z   = 2;
  localparam int unsigned IDX_PD  = 3;
  localparam int unsigned IDX_TO  = 4;
  localparam int unsigned BANK_LO = 5;
  localparam int unsigned BANK_HI = BANK_LO + BANK_N - 1;
  localparam int unsigned FLAG_HI = FLAG_N - 1;

  typedef struct packed {
    logic time_out;
    logic power_down;
  } wake_bits_t;
endpackage

// File: rtl/sreg_bank_field.sv
module sreg_bank_field #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_bits,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (wr_en)
      q <= wr_bits;
  end
endmodule

// File: rtl/sreg_flag_cell.sv
module sreg_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_en,
  input  logic bus_bit,
  input  logic bus_block,
  input  logic alu_we,
  input  logic alu_bit,
  output logic q
);
  logic nxt;

  always_comb begin
    nxt = q;
    if (alu_we)
      nxt = alu_bit;
    else if (bus_en && !bus_block)
      nxt = bus_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/sreg_wake_bits.sv
module sreg_wake_bits
  import sreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_evt,
  input  logic       sleep_evt,
  input  logic       expire_evt,
  output wake_bits_t q
);
  wake_bits_t nxt;

  always_comb begin
    nxt = q;
    if (clr_evt)   nxt.power_down = 1'b1;
    if (sleep_evt) nxt.power_down = 1'b0;
    if (clr_evt || sleep_evt) nxt.time_out = 1'b1;
    if (expire_evt) nxt.time_out = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '{time_out: 1'b1, power_down: 1'b1};
    else        q <= nxt;
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [WORD_W-1:0] bus_wr_data,
  input  logic              alu_z_we,
  input  logic              alu_dc_we,
  input  logic              alu_c_we,
  input  logic              alu_z,
  input  logic              alu_dc,
  input  logic              alu_c,
  input  logic              wdt_clear_evt,
  input  logic              sleep_evt,
  input  logic              wdt_expire_evt,
  output logic [WORD_W-1:0] status_q,
  output logic              ind_bank,
  output logic [1:0]        dir_bank
);
  logic [FLAG_N-1:0] flag_we;
  logic [FLAG_N-1:0] flag_val;
  logic [FLAG_N-1:0] flag_q;
  logic [BANK_N-1:0] bank_q;
  logic              any_flag_we;
  wake_bits_t        wake_q;
  logic [1:0]        unused_wake_data;

  assign flag_we     = {alu_z_we, alu_dc_we, alu_c_we};
  assign flag_val    = {alu_z, alu_dc, alu_c};
  assign any_flag_we = |flag_we;
  assign unused_wake_data = bus_wr_data[IDX_TO:IDX_PD];

  sreg_bank_field #(.WIDTH(BANK_N)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr_en),
    .wr_bits(bus_wr_data[BANK_HI:BANK_LO]),
    .q      (bank_q)
  );

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    sreg_flag_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_en   (bus_wr_en),
      .bus_bit  (bus_wr_data[i]),
      .bus_block(any_flag_we),
      .alu_we   (flag_we[i]),
      .alu_bit  (flag_val[i]),
      .q        (flag_q[i])
    );
  end

  sreg_wake_bits u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_evt   (wdt_clear_evt),
    .sleep_evt (sleep_evt),
    .expire_evt(wdt_expire_evt),
    .q         (wake_q)
  );

  assign status_q = {bank_q, wake_q.time_out, wake_q.power_down, flag_q};
  assign ind_bank = bank_q[BANK_N-1];
  assign dir_bank = bank_q[1:0];
endmodule

// File: rtl/cpu_status_reg_chk.sv
module cpu_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr_en,
  input logic [7:0] bus_wr_data,
  input logic       alu_z_we,
  input logic       alu_dc_we,
  input logic       alu_c_we,
  input logic       alu_z,
  input logic       alu_dc,
  input logic       alu_c,
  input logic       wdt_clear_evt,
  input logic       sleep_evt,
  input logic       wdt_expire_evt,
  input logic [7:0] status_q
);
  logic any_we;
  logic no_evt;
  assign any_we = alu_z_we | alu_dc_we | alu_c_we;
  assign no_evt = !wdt_clear_evt && !sleep_evt && !wdt_expire_evt;

  a_r1_reset_value: assert property (@(posedge clk)
    !rst_n |=> (status_q[7:3] == 5'b00011));

  a_r2_bus_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !any_we) |=>
      (status_q[7:5] == $past(bus_wr_data[7:5])) && (status_q[2:0] == $past(bus_wr_data[2:0])));

  a_r3_flag_block: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && any_we) |=>
      (status_q[7:5] == $past(bus_wr_data[7:5])) &&
      (status_q[2] == ($past(alu_z_we)  ? $past(alu_z)  : $past(status_q[2]))) &&
      (status_q[1] == ($past(alu_dc_we) ? $past(alu_dc) : $past(status_q[1]))) &&
      (status_q[0] == ($past(alu_c_we)  ? $past(alu_c)  : $past(status_q[0]))));

  a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_en && !any_we) |=> $stable(status_q[2:0]));

  a_r5_wake_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    no_evt |=> $stable(status_q[4:3]));

  a_r6_clear_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clear_evt && !sleep_evt && !wdt_expire_evt) |=> (status_q[4:3] == 2'b11));

  a_r7_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_evt && !wdt_expire_evt) |=> (status_q[4:3] == 2'b10));

  a_r8_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_expire_evt && !wdt_clear_evt && !sleep_evt) |=>
      (!status_q[4] && (status_q[3] == $past(status_q[3]))));

  a_r9_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_expire_evt && wdt_clear_evt && !sleep_evt) |=> (status_q[4:3] == 2'b01));
endmodule

bind cpu_status_reg cpu_status_reg_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr_en     (bus_wr_en),
  .bus_wr_data   (bus_wr_data),
  .alu_z_we      (alu_z_we),
  .alu_dc_we     (alu_dc_we),
  .alu_c_we      (alu_c_we),
  .alu_z         (alu_z),
  .alu_dc        (alu_dc),
  .alu_c         (alu_c),
  .wdt_clear_evt (wdt_clear_evt),
  .sleep_evt     (sleep_evt),
  .wdt_expire_evt(wdt_expire_evt),
  .status_q      (status_q)
);

// File: tb/tb_cpu_status_reg.sv
module tb_cpu_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wr_data = 8'h00;
  logic       alu_z_we = 1'b0, alu_dc_we = 1'b0, alu_c_we = 1'b0;
  logic       alu_z = 1'b0, alu_dc = 1'b0, alu_c = 1'b0;
  logic       wdt_clear_evt = 1'b0, sleep_evt = 1'b0, wdt_expire_evt = 1'b0;
  logic [7:0] status_q;
  logic       ind_bank;
  logic [1:0] dir_bank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cpu_status_reg dut (.*);

  // {we, data[8], en zdc c[3], val z dc c[3], clr sleep expire[3], expected[8]}
  localparam int NV = 17;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 8'hFF, 3'b000, 3'b000, 3'b000, 8'hFF},  // R2 R5
    {1'b1, 8'h00, 3'b000, 3'b000, 3'b000, 8'h18},  // R2
    {1'b0, 8'hFF, 3'b101, 3'b101, 3'b000, 8'h1D},  // R4
    {1'b0, 8'h00, 3'b010, 3'b010, 3'b000, 8'h1F},  // R4
    {1'b1, 8'hE0, 3'b000, 3'b111, 3'b000, 8'hF8},  // R2
    {1'b0, 8'h00, 3'b001, 3'b001, 3'b000, 8'hF9},  // R4
    {1'b1, 8'h00, 3'b100, 3'b100, 3'b000, 8'h1D},  // R11
    {1'b1, 8'hA2, 3'b001, 3'b000, 3'b000, 8'hBC},  // R3
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b010, 8'hB4},  // R7
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b001, 8'hA4},  // R8
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b100, 8'hBC},  // R6
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b101, 8'hAC},  // R9
    {1'b1, 8'h07, 3'b000, 3'b000, 3'b000, 8'h0F},  // R5
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b110, 8'h17},  // R12
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b011, 8'h07},  // R9
    {1'b0, 8'hFF, 3'b000, 3'b111, 3'b000, 8'h07},  // R4
    {1'b1, 8'hFF, 3'b000, 3'b000, 3'b000, 8'hE7}   // R5
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic [7:0] exp);
    check(req, status_q, exp);
    check("R10", {5'b0, ind_bank, dir_bank}, {5'b0, exp[7:5]});
  endtask

  task automatic idle_inputs();
    bus_wr_en = 1'b0; bus_wr_data = 8'h00;
    {alu_z_we, alu_dc_we, alu_c_we} = 3'b000;
    {alu_z, alu_dc, alu_c} = 3'b000;
    {wdt_clear_evt, sleep_evt, wdt_expire_evt} = 3'b000;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outs("R1", 8'h18);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1", 8'h18);

    for (int i = 0; i < NV; i++) begin
      bus_wr_en   = VEC[i][25];
      bus_wr_data = VEC[i][24:17];
      {alu_z_we, alu_dc_we, alu_c_we} = VEC[i][16:14];
      {alu_z, alu_dc, alu_c}          = VEC[i][13:11];
      {wdt_clear_evt, sleep_evt, wdt_expire_evt} = VEC[i][10:8];
      @(negedge clk);
      check_outs($sformatf("vector %0d", i), VEC[i][7:0]);
    end
    idle_inputs();

    // R3: discarded bus flag data with only carry enabled, from flags 111
    bus_wr_en = 1'b1; bus_wr_data = 8'h40; alu_c_we = 1'b1; alu_c = 1'b0;
    @(negedge clk);
    idle_inputs();
    check_outs("R3", 8'h46);

    // R5: bus write of zeros while time-out and power-down differ from data
    wdt_clear_evt = 1'b1;
    @(negedge clk);
    idle_inputs();
    check_outs("R6", 8'h5E);
    bus_wr_en = 1'b1; bus_wr_data = 8'h00;
    @(negedge clk);
    idle_inputs();
    check_outs("R5", 8'h18);

    // R4: hold with no activity for several cycles
    repeat (3) @(negedge clk);
    check_outs("R4", 8'h18);

    // R1: reset in mid-run restores power-up state
    bus_wr_en = 1'b1; bus_wr_data = 8'hE7; sleep_evt = 1'b1;
    @(negedge clk);
    idle_inputs();
    check_outs("R7", 8'hF7);
    rst_n = 1'b0;
    #2;
    check_outs("R1", 8'h18);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1", 8'h18);

    finish_run();
  end
endmodule